// File: doc/BRIEF.md
# Power-Cycle Mode Programmer Sequencer

This block hands a small mode number to a target device that has no data pins, by switching the target's power on and off a counted number of times. The target counts the power cycles it sees. The block drives one active-low power-enable line. A low level supplies power to the target.

Every start begins with the line held off for a settling delay. The block then reads two reset-cause indications. A power-on start leaves the target powered and does nothing else. A start from the program button first holds power off for a short marking delay. It then reads a 4-bit rotary switch, whose lines are active-low. It converts the switch reading to a pulse count by adding a fixed guard offset. It emits that many on/off pulses and then leaves the target powered for good. An optional build variant scales the count so that the receiving side can tolerate a miscount of one. All delays are given as clock ticks, and all inputs pass through a two-flop synchronizer.

Top module: `pcycle_mode_prog`

## Requirements
- R1: For the first DEBOUNCE_TICKS cycles after `rst` is released, `pwr_en_n_o` is high (off), whatever the reset cause. The output is also high while `rst` is asserted.
- R2: If `por_flag_i` is high when the settling delay ends, `pwr_en_n_o` goes low and stays low, and no pulses are emitted.
- R3: The power-on indication takes priority over the button indication. When both are high, or when neither is high, the block behaves as in R2.
- R4: After a button start (`por_flag_i` low, `btn_flag_i` high), the output stays high for a further STAB_TICKS cycles, so it is high for DEBOUNCE_TICKS+STAB_TICKS cycles in total before the first pulse.
- R5: The switch value is code = ~`mode_sw_n_i` (so 4'hF reads as mode 0). The number of pulses is code + GUARD_OFFSET, where GUARD_OFFSET defaults to 15. Mode 0 therefore gives 15 pulses.
- R6: Each pulse drives `pwr_en_n_o` low for exactly ON_TICKS cycles, then high for exactly OFF_TICKS cycles.
- R7: After the high phase of the last pulse, `pwr_en_n_o` goes low and stays low until the next reset.
- R8: The switch is read once, on the cycle the marking delay ends. Later changes to `mode_sw_n_i` do not change the pulse count.
- R9: With NOISE_IMMUNE=1, the number of pulses is (code + GUARD_OFFSET + 1) * 4.
- R10: Asserting `rst` in the middle of a pulse train forces `pwr_en_n_o` high at the next clock edge. After release, the whole sequence restarts from the settling delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new sequence when released |
| por_flag_i | input | 1 | The start was a power-on reset |
| btn_flag_i | input | 1 | The start was a program-button reset |
| mode_sw_n_i | input | MODE_W | Active-low mode switch lines |
| pwr_en_n_o | output | 1 | Active-low power enable for the target, registered |

## Verification
The assertions assume that the reset-cause flags and the switch lines are steady for at least the two synchronizer cycles before they are read. The flags are read when the settling delay ends, and the switch is read when the marking delay ends. The assertions also assume that every tick parameter is at least one. The stimulus sets the flags and the switch while `rst` is held and keeps the flags constant for the whole run. Its settling delay is longer than the synchronizer depth. The only switch change it makes happens after the switch has been read, so that the R8 check exercises the late-change case.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [2:0] {
    PMP_SETTLE,
    PMP_MARK,
    PMP_PULSE_ON,
    PMP_PULSE_OFF,
    PMP_PARK
  } pmp_state_e;
endpackage

// File: rtl/pmp_sync.sv
module pmp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[g] <= '0;
        else     stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[g] <= '0;
        else     stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pmp_timer.sv
module pmp_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  // Loaded with ticks-1, so a phase lasts exactly "ticks" cycles.
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= TW'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R6
endmodule

// File: rtl/pmp_encode.sv
module pmp_encode #(
  parameter int MODE_W       = 4,
  parameter int GUARD_OFFSET = 15,
  parameter bit NOISE_IMMUNE = 1'b0,
  parameter int CNT_W        = 8
) (
  input  logic [MODE_W-1:0] sw_n_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [MODE_W-1:0] code;
  logic [CNT_W-1:0]  base;

  assign code = ~sw_n_i;
  assign base = CNT_W'(code) + CNT_W'(GUARD_OFFSET);

  if (NOISE_IMMUNE) begin : g_scaled
    logic [CNT_W-1:0] plus1;
    assign plus1   = base + 1'b1;
    assign count_o = {plus1[CNT_W-3:0], 2'b00};
  end else begin : g_plain
    assign count_o = base;
  end
endmodule

// File: rtl/pmp_fsm.sv
module pmp_fsm
  import pmp_pkg::*;
#(
  parameter int TW         = 8,
  parameter int CNT_W      = 8,
  parameter int STAB_TICKS = 4,
  parameter int ON_TICKS   = 4,
  parameter int OFF_TICKS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_i,
  input  logic             btn_i,
  input  logic             expired_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic [TW-1:0]    load_val_o,
  output logic             pwr_en_n_o
);
  pmp_state_e       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             out_d;

  always_comb begin
    state_d    = state_q;
    remain_d   = remain_q;
    load_o     = 1'b0;
    load_val_o = '0;
    case (state_q)
      PMP_SETTLE: if (expired_i) begin
        if (por_i || !btn_i) begin
          state_d = PMP_PARK;
        end else begin
          state_d    = PMP_MARK;
          load_o     = 1'b1;
          load_val_o = TW'(STAB_TICKS - 1);
        end
      end
      PMP_MARK: if (expired_i) begin
        remain_d = count_i;
        if (count_i == '0) begin
          state_d = PMP_PARK;
        end else begin
          state_d    = PMP_PULSE_ON;
          load_o     = 1'b1;
          load_val_o = TW'(ON_TICKS - 1);
        end
      end
      PMP_PULSE_ON: if (expired_i) begin
        state_d    = PMP_PULSE_OFF;
        load_o     = 1'b1;
        load_val_o = TW'(OFF_TICKS - 1);
      end
      PMP_PULSE_OFF: if (expired_i) begin
        remain_d = remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) begin
          state_d = PMP_PARK;
        end else begin
          state_d    = PMP_PULSE_ON;
          load_o     = 1'b1;
          load_val_o = TW'(ON_TICKS - 1);
        end
      end
      default: state_d = PMP_PARK;
    endcase
    out_d = !(state_d == PMP_PULSE_ON || state_d == PMP_PARK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PMP_SETTLE;
      remain_q   <= '0;
      pwr_en_n_o <= 1'b1;
    end else begin
      state_q    <= state_d;
      remain_q   <= remain_d;
      pwr_en_n_o <= out_d;
    end
  end

  AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pwr_en_n_o); // R1
  AST_POR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PMP_SETTLE && expired_i && por_i) |=> state_q == PMP_PARK); // R3
  AST_PULSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == PMP_PULSE_ON || state_q == PMP_PULSE_OFF) |-> remain_q != '0); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == PMP_PULSE_OFF && expired_i) |=> remain_q == $past(remain_q) - 1'b1); // R5
  AST_PARK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PMP_PARK) |=> (state_q == PMP_PARK && !pwr_en_n_o)); // R7
endmodule

// File: rtl/pcycle_mode_prog.sv
module pcycle_mode_prog #(
  parameter int MODE_W         = 4,
  parameter int GUARD_OFFSET   = 15,
  parameter bit NOISE_IMMUNE   = 1'b0,
  parameter int DEBOUNCE_TICKS = 30000000,
  parameter int STAB_TICKS     = 1500000,
  parameter int ON_TICKS       = 5000000,
  parameter int OFF_TICKS      = 5000000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_flag_i,
  input  logic              btn_flag_i,
  input  logic [MODE_W-1:0] mode_sw_n_i,
  output logic              pwr_en_n_o
);
  localparam int MAX_A = (DEBOUNCE_TICKS > STAB_TICKS) ? DEBOUNCE_TICKS : STAB_TICKS;
  localparam int MAX_B = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam int MAX_C = ((2 ** MODE_W) + GUARD_OFFSET) * 4;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int SW    = MODE_W + 2;

  logic [SW-1:0]     raw_in, synced;
  logic              por_s, btn_s;
  logic [MODE_W-1:0] sw_n_s;
  logic [CNT_W-1:0]  count;
  logic              load, expired;
  logic [TW-1:0]     load_val;

  assign raw_in = {por_flag_i, btn_flag_i, mode_sw_n_i};
  assign por_s  = synced[SW-1];
  assign btn_s  = synced[SW-2];
  assign sw_n_s = synced[MODE_W-1:0];

  pmp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(synced)
  );

  pmp_encode #(
    .MODE_W(MODE_W), .GUARD_OFFSET(GUARD_OFFSET),
    .NOISE_IMMUNE(NOISE_IMMUNE), .CNT_W(CNT_W)
  ) u_encode (
    .sw_n_i(sw_n_s), .count_o(count)
  );

  pmp_timer #(.TW(TW), .RST_VAL(DEBOUNCE_TICKS - 1)) u_timer (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val),
    .expired_o(expired)
  );

  pmp_fsm #(
    .TW(TW), .CNT_W(CNT_W), .STAB_TICKS(STAB_TICKS),
    .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .por_i(por_s), .btn_i(btn_s),
    .expired_i(expired), .count_i(count), .load_o(load),
    .load_val_o(load_val), .pwr_en_n_o(pwr_en_n_o)
  );
endmodule

// File: tb/test_pcycle_mode_prog.sv
module test_pcycle_mode_prog;
  localparam int DEB = 5, STB = 3, ONT = 4, OFFT = 2, TAIL = 20;
  localparam int NV = 8;
  // {por, btn, sw_n, sw_n applied after read, expected plain pulses}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'hF, 4'hF, 8'd0},   // R2
    {1'b1, 1'b1, 4'h0, 4'h0, 8'd0},   // R3 both
    {1'b0, 1'b0, 4'h0, 4'h0, 8'd0},   // R3 neither
    {1'b0, 1'b1, 4'hF, 4'hF, 8'd15},  // R5 mode 0
    {1'b0, 1'b1, 4'h0, 4'hF, 8'd30},  // R5 mode 15, R8 late change
    {1'b0, 1'b1, 4'hA, 4'h0, 8'd20},  // R8
    {1'b0, 1'b1, 4'h5, 4'h5, 8'd25},
    {1'b0, 1'b1, 4'hE, 4'hE, 8'd16}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, por = 1'b0, btn = 1'b0;
  logic [3:0] sw_n = 4'hF;
  logic       out0, out1;
  int         errs = 0, checks = 0;

  pcycle_mode_prog #(.DEBOUNCE_TICKS(DEB), .STAB_TICKS(STB), .ON_TICKS(ONT),
    .OFF_TICKS(OFFT)) i_pcycle_mode_prog (
    .clk(clk), .rst(rst), .por_flag_i(por), .btn_flag_i(btn),
    .mode_sw_n_i(sw_n), .pwr_en_n_o(out0));

  pcycle_mode_prog #(.NOISE_IMMUNE(1'b1), .DEBOUNCE_TICKS(DEB), .STAB_TICKS(STB),
    .ON_TICKS(ONT), .OFF_TICKS(OFFT)) i_pcycle_mode_prog_ni (
    .clk(clk), .rst(rst), .por_flag_i(por), .btn_flag_i(btn),
    .mode_sw_n_i(sw_n), .pwr_en_n_o(out1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic p, input logic b, input logic [3:0] s,
                          input logic [3:0] late, input int exp0);
    int  expn [2];
    int  run [2], pulses [2], first_hi [2], bad_on [2], bad_off [2];
    bit  first_done [2];
    logic prev [2], v [2];
    int  total;
    @(negedge clk);
    rst = 1'b1; por = p; btn = b; sw_n = s;
    repeat (2) @(negedge clk);
    check(out0 == 1'b1 && out1 == 1'b1, "R1 held in reset", out0, 1);
    rst = 1'b0;
    expn[0] = exp0;
    expn[1] = (exp0 != 0) ? (exp0 + 1) * 4 : 0;
    total = DEB + STB + expn[1] * (ONT + OFFT) + TAIL;
    for (int k = 0; k < 2; k++) begin
      run[k] = 0; pulses[k] = 0; first_hi[k] = 0;
      bad_on[k] = 0; bad_off[k] = 0; first_done[k] = 1'b0; prev[k] = 1'b1;
    end
    for (int i = 0; i < total; i++) begin
      if (i > 0) @(negedge clk);
      if (i == DEB + STB + 1) sw_n = late;
      v[0] = out0; v[1] = out1;
      for (int k = 0; k < 2; k++) begin
        if (i == 0) begin
          prev[k] = v[k]; run[k] = 1;
        end else if (v[k] == prev[k]) begin
          run[k]++;
        end else begin
          if (!first_done[k]) begin
            first_hi[k] = run[k]; first_done[k] = 1'b1;
          end else if (prev[k] == 1'b0) begin
            pulses[k]++;
            if (run[k] != ONT) bad_on[k]++;
          end else if (run[k] != OFFT) begin
            bad_off[k]++;
          end
          prev[k] = v[k]; run[k] = 1;
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      if (exp0 == 0)
        check(first_hi[k] == DEB, "R1 R2 settle then on", first_hi[k], DEB);
      else
        check(first_hi[k] == DEB + STB, "R1 R4 settle plus mark", first_hi[k], DEB + STB);
      if (k == 0)
        check(pulses[k] == expn[k], "R5 R8 pulse count", pulses[k], expn[k]);
      else
        check(pulses[k] == expn[k], "R9 scaled pulse count", pulses[k], expn[k]);
      check(bad_on[k] == 0 && bad_off[k] == 0, "R6 pulse widths", bad_on[k] + bad_off[k], 0);
      check(prev[k] == 1'b0 && run[k] >= TAIL, "R7 parked on", run[k], TAIL);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out0 == 1'b1, "R1 reset state", out0, 1);
    for (int n = 0; n < NV; n++) begin
      run_case(VEC[n][17], VEC[n][16], VEC[n][15:12], VEC[n][11:8], int'(VEC[n][7:0]));
    end
    // R10: reset in the middle of a pulse train, then a full restart
    @(negedge clk);
    rst = 1'b1; por = 1'b0; btn = 1'b1; sw_n = 4'hF;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (DEB + STB + 2) @(negedge clk);
    check(out0 == 1'b0, "R6 inside first on phase", out0, 0);
    rst = 1'b1;
    @(negedge clk);
    check(out0 == 1'b1 && out1 == 1'b1, "R10 off after reset", out0, 1);
    run_case(1'b0, 1'b1, 4'hF, 4'hF, 15); // R10 restart
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule